// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs the byte-wide bus of a NAND flash device (528-byte pages, 16 pages per block, 512 blocks) on behalf of a host. The host posts one request at a time: an opcode, a 24-bit byte address and a byte count. The block selects the device and produces the command, address and data strobe cycles for a page read, a page program or a block erase. Each write-enable and read-enable phase lasts for a parameterised number of clock cycles. The block waits out the device's busy period and, after an erase, reads the status byte to decide whether the erase worked.

Program data is pulled from the host over a valid/ready byte stream. Read data is pushed to the host as one-cycle valid pulses. A busy flag covers the whole operation. A one-cycle completion pulse comes with a pass/fail flag. A failed erase is repeated once on its own; only a second failure is reported to the host.

Top module: `nand_seq_top`

## Requirements
- R1: After reset, chip enable, write enable and read enable are all high (inactive), the command and address latch strobes are low, and busy and done are low.
- R2: A byte is latched on the rising edge of write enable. It is a command byte when the command latch is 1 and the address latch is 0. It is an address byte when the command latch is 0 and the address latch is 1. It is a data byte when both latches are 0.
- R3: From the cycle after a request is taken until the done pulse, busy is high and chip enable stays low. Done is a single-cycle pulse, and chip enable goes high in the same cycle.
- R4: Opcode 0 (read) sends command 00h, then address bits 7:0, 15:8 and 23:16 in that order, waits for ready, then performs the requested number of read-enable cycles. Each byte read is delivered on rdValid in the order it came from the device. Pass is 1.
- R5: Opcode 1 (program) sends command 80h and the three address bytes in the same order as R4. It then takes the requested number of bytes over the wrValid/wrReady handshake and writes them in order, sends command 10h, and waits for ready. Pass is 1.
- R6: Opcode 2 (erase) sends command 60h, then address bits 15:8 and 23:16, then command D0h.
- R7: After the read address bytes and after each confirm command, no strobe is pulsed until BUSY_DLY cycles have passed and the ready input is high.
- R8: After the erase busy period, the block sends command 70h and reads one status byte. If bit 0 is 0, the erase passes. If bit 0 is 1, the whole erase sequence of R6 and R8 is run once more. If that second attempt also fails, the block reports pass = 0.
- R9: Every write-enable low phase lasts at least WE_LO cycles, and consecutive write-enable pulses are separated by at least WE_HI high cycles. Every read-enable low phase lasts at least RE_LO cycles, and every read-enable high phase lasts at least RE_HI cycles.
- R10: Write enable and read enable are never low together, the command and address latches are never both high, and the data bus is driven only during write cycles.
- R11: A request presented while busy is high has no effect: the bus sequence and the result are those of the operation already running.
- R12: Opcode 3 is ignored: no bus activity takes place and busy stays low.
- R13: A request with a byte count of 0 sends no data-phase cycles and still completes with its confirm, busy wait and done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe; taken when idle |
| reqOp | input | 2 | 0 read, 1 program, 2 erase, 3 ignored |
| reqAddr | input | 24 | Byte address |
| reqLen | input | LEN_W | Number of data bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last operation |
| wrValid | input | 1 | Program byte available |
| wrData | input | 8 | Program byte |
| wrReady | output | 1 | Program byte accepted when wrValid is also high |
| rdValid | output | 1 | Read byte valid (one cycle) |
| rdData | output | 8 | Read byte |
| fceN | output | 1 | Device chip enable, active low |
| fcle | output | 1 | Command latch strobe |
| fale | output | 1 | Address latch strobe |
| fweN | output | 1 | Write enable, active low |
| freN | output | 1 | Read enable, active low |
| fdqOut | output | 8 | Bus value driven to the device |
| fdqOe | output | 1 | Bus output enable |
| fdqIn | input | 8 | Bus value from the device |
| frdy | input | 1 | Device ready (high) / busy (low) |

## Verification
The bench attacks the erase status path with zero, one and two injected failures. A design that skips the retry would report failure on a single bad status. A design that loops would hang, or would send a third 60h. Byte counts of 0 and a full 528-byte page check the data-phase bounds, where an off-by-one gives an extra or a missing strobe in the logged bus trace. A behavioural device model holds ready low for a random time and counts any strobe issued while busy. A second request injected mid-operation, and opcode 3, must leave the bus trace unchanged. A latch that mixes up its qualifiers, or a wrong address byte order, shows up as a kind or byte mismatch against the trace the bench expects.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

  localparam int ADDR_W = 24;

  localparam logic [7:0] CMD_RD_SETUP = 8'h00;
  localparam logic [7:0] CMD_PG_SETUP = 8'h80;
  localparam logic [7:0] CMD_PG_GO    = 8'h10;
  localparam logic [7:0] CMD_ER_SETUP = 8'h60;
  localparam logic [7:0] CMD_ER_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    CY_CMD, CY_ADDR, CY_WDATA, CY_RDATA, CY_WAIT
  } cyc_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       go;
    logic       ce;
    cyc_e       kind;
    logic [7:0] dat;
  } strb_t;

endpackage

// File: rtl/nand_seq_dpath.sv
`timescale 1ns/1ps
module nand_seq_dpath
  import nand_seq_pkg::*;
#(
  parameter int WE_LO    = 2,
  parameter int WE_HI    = 1,
  parameter int RE_LO    = 3,
  parameter int RE_HI    = 2,
  parameter int BUSY_DLY = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  strb_t      strb,
  input  logic       frdy,
  input  logic [7:0] fdqIn,
  output logic       cycDone,
  output logic [7:0] rdByte,
  output logic       fceN,
  output logic       fcle,
  output logic       fale,
  output logic       fweN,
  output logic       freN,
  output logic [7:0] fdqOut,
  output logic       fdqOe
);

  localparam int M_WE  = (WE_LO > WE_HI) ? WE_LO : WE_HI;
  localparam int M_RE  = (RE_LO > RE_HI) ? RE_LO : RE_HI;
  localparam int M_STB = (M_WE > M_RE) ? M_WE : M_RE;
  localparam int M_ALL = (M_STB > BUSY_DLY) ? M_STB : BUSY_DLY;
  localparam int CNT_W = $clog2(M_ALL + 1);

  typedef enum logic [1:0] {P_IDLE, P_LO, P_HI, P_WT} phase_e;

  phase_e           phase;
  cyc_e             kindQ;
  logic [7:0]       datQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loLim, hiLim;
  logic             active, isRd;

  assign isRd   = (kindQ == CY_RDATA);
  assign loLim  = isRd ? CNT_W'(RE_LO - 1) : CNT_W'(WE_LO - 1);
  assign hiLim  = isRd ? CNT_W'(RE_HI - 1) : CNT_W'(WE_HI - 1);
  assign active = (phase == P_LO) || (phase == P_HI);

  assign cycDone = ((phase == P_HI) && (cnt == hiLim)) ||
                   ((phase == P_WT) && (cnt >= CNT_W'(BUSY_DLY)) && frdy);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= P_IDLE;
      kindQ  <= CY_CMD;
      datQ   <= '0;
      cnt    <= '0;
      rdByte <= '0;
    end else begin
      case (phase)
        P_IDLE: if (strb.go) begin
          kindQ <= strb.kind;
          datQ  <= strb.dat;
          cnt   <= '0;
          phase <= (strb.kind == CY_WAIT) ? P_WT : P_LO;
        end
        P_LO: if (cnt == loLim) begin
          phase <= P_HI;
          cnt   <= '0;
          if (isRd) rdByte <= fdqIn;
        end else begin
          cnt <= cnt + 1'b1;
        end
        P_HI: if (cnt == hiLim) phase <= P_IDLE;
              else cnt <= cnt + 1'b1;
        default: if (cnt < CNT_W'(BUSY_DLY)) cnt <= cnt + 1'b1;
                 else if (frdy) phase <= P_IDLE;
      endcase
    end
  end

  assign fceN   = !strb.ce;
  assign fcle   = active && (kindQ == CY_CMD);
  assign fale   = active && (kindQ == CY_ADDR);
  assign fweN   = !((phase == P_LO) && !isRd);
  assign freN   = !((phase == P_LO) && isRd);
  assign fdqOe  = active && !isRd;
  assign fdqOut = datQ;

  // strobe width watch counters (saturating)
  logic [7:0] weLowRun, weHighRun, reLowRun, reHighRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowRun  <= '0;
      reLowRun  <= '0;
      weHighRun <= 8'hFF;
      reHighRun <= 8'hFF;
    end else begin
      weLowRun  <= fweN  ? '0 : ((weLowRun  == 8'hFF) ? 8'hFF : weLowRun  + 8'd1);
      reLowRun  <= freN  ? '0 : ((reLowRun  == 8'hFF) ? 8'hFF : reLowRun  + 8'd1);
      weHighRun <= !fweN ? '0 : ((weHighRun == 8'hFF) ? 8'hFF : weHighRun + 8'd1);
      reHighRun <= !freN ? '0 : ((reHighRun == 8'hFF) ? 8'hFF : reHighRun + 8'd1);
    end
  end

  // R9
  we_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fweN) |-> (weLowRun >= 8'(WE_LO)));
  // R9
  we_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fweN) |-> (weHighRun >= 8'(WE_HI)));
  // R9
  re_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(freN) |-> (reLowRun >= 8'(RE_LO)));
  // R9
  re_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(freN) |-> (reHighRun >= 8'(RE_HI)));
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!fweN && !freN));
  // R10
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fcle && fale));
  // R3
  ce_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fweN || !freN) |-> !fceN);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == P_WT) && !frdy) |=> (phase == P_WT));

endmodule

// File: rtl/nand_seq_ctrl.sv
`timescale 1ns/1ps
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              busy,
  output logic              done,
  output logic              pass,
  input  logic              wrValid,
  input  logic [7:0]        wrData,
  output logic              wrReady,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output strb_t             strb,
  input  logic              cycDone,
  input  logic [7:0]        rdByte
);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_WAITR, S_RDATA, S_WDATA,
    S_CONF, S_WAITC, S_STCMD, S_STRD
  } state_e;

  state_e            state;
  op_e               opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [LEN_W-1:0]  lenQ, cnt;
  logic [1:0]        addrIdx;
  logic              issued, retried;
  logic [7:0]        addrByte;
  logic              step, lastByte;

  assign busy     = (state != S_IDLE);
  assign step     = issued && cycDone;
  assign lastByte = ((cnt + LEN_W'(1)) == lenQ);

  always_comb begin
    case (addrIdx)
      2'd0:    addrByte = addrQ[7:0];
      2'd1:    addrByte = addrQ[15:8];
      default: addrByte = addrQ[23:16];
    endcase
  end

  always_comb begin
    strb    = '0;
    strb.ce = busy;
    wrReady = 1'b0;
    case (state)
      S_CMD: begin
        strb.kind = CY_CMD;
        strb.dat  = (opQ == OP_READ) ? CMD_RD_SETUP :
                    (opQ == OP_PROG) ? CMD_PG_SETUP : CMD_ER_SETUP;
        strb.go   = !issued;
      end
      S_ADDR: begin
        strb.kind = CY_ADDR;
        strb.dat  = addrByte;
        strb.go   = !issued;
      end
      S_WAITR, S_WAITC: begin
        strb.kind = CY_WAIT;
        strb.go   = !issued;
      end
      S_RDATA, S_STRD: begin
        strb.kind = CY_RDATA;
        strb.go   = !issued;
      end
      S_WDATA: begin
        strb.kind = CY_WDATA;
        strb.dat  = wrData;
        wrReady   = !issued;
        strb.go   = !issued && wrValid;
      end
      S_CONF: begin
        strb.kind = CY_CMD;
        strb.dat  = (opQ == OP_PROG) ? CMD_PG_GO : CMD_ER_GO;
        strb.go   = !issued;
      end
      S_STCMD: begin
        strb.kind = CY_CMD;
        strb.dat  = CMD_STATUS;
        strb.go   = !issued;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opQ     <= OP_NONE;
      addrQ   <= '0;
      lenQ    <= '0;
      cnt     <= '0;
      addrIdx <= '0;
      issued  <= 1'b0;
      retried <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      done    <= 1'b0;
      rdValid <= 1'b0;
      if (strb.go) issued <= 1'b1;
      if (state == S_IDLE) begin
        if (reqValid && (reqOp != 2'd3)) begin
          opQ     <= op_e'(reqOp);
          addrQ   <= reqAddr;
          lenQ    <= reqLen;
          cnt     <= '0;
          retried <= 1'b0;
          issued  <= 1'b0;
          state   <= S_CMD;
        end
      end else if (step) begin
        issued <= 1'b0;
        case (state)
          S_CMD: begin
            state   <= S_ADDR;
            addrIdx <= (opQ == OP_ERASE) ? 2'd1 : 2'd0;
          end
          S_ADDR: begin
            if (addrIdx == 2'd2) begin
              cnt <= '0;
              if (opQ == OP_READ)      state <= S_WAITR;
              else if (opQ == OP_PROG) state <= (lenQ == '0) ? S_CONF : S_WDATA;
              else                     state <= S_CONF;
            end else begin
              addrIdx <= addrIdx + 2'd1;
            end
          end
          S_WAITR: begin
            if (lenQ == '0) begin
              state <= S_IDLE; done <= 1'b1; pass <= 1'b1;
            end else begin
              state <= S_RDATA;
            end
          end
          S_RDATA: begin
            rdValid <= 1'b1;
            rdData  <= rdByte;
            cnt     <= cnt + 1'b1;
            if (lastByte) begin
              state <= S_IDLE; done <= 1'b1; pass <= 1'b1;
            end
          end
          S_WDATA: begin
            cnt <= cnt + 1'b1;
            if (lastByte) state <= S_CONF;
          end
          S_CONF:  state <= S_WAITC;
          S_WAITC: begin
            if (opQ == OP_PROG) begin
              state <= S_IDLE; done <= 1'b1; pass <= 1'b1;
            end else begin
              state <= S_STCMD;
            end
          end
          S_STCMD: state <= S_STRD;
          S_STRD: begin
            if (!rdByte[0]) begin
              state <= S_IDLE; done <= 1'b1; pass <= 1'b1;
            end else if (!retried) begin
              retried <= 1'b1;
              state   <= S_CMD;
            end else begin
              state <= S_IDLE; done <= 1'b1; pass <= 1'b0;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R8
  status_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_STRD) && step && !rdByte[0]) |=> (done && pass));
  // R8
  fail_after_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pass) |-> retried);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R4
  rd_in_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(busy));

endmodule

// File: rtl/nand_seq_top.sv
`timescale 1ns/1ps
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int LEN_W    = 10,
  parameter int WE_LO    = 2,
  parameter int WE_HI    = 1,
  parameter int RE_LO    = 3,
  parameter int RE_HI    = 2,
  parameter int BUSY_DLY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [23:0]       reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              busy,
  output logic              done,
  output logic              pass,
  input  logic              wrValid,
  input  logic [7:0]        wrData,
  output logic              wrReady,
  output logic              rdValid,
  output logic [7:0]        rdData,
  output logic              fceN,
  output logic              fcle,
  output logic              fale,
  output logic              fweN,
  output logic              freN,
  output logic [7:0]        fdqOut,
  output logic              fdqOe,
  input  logic [7:0]        fdqIn,
  input  logic              frdy
);

  strb_t      strb;
  logic       cycDone;
  logic [7:0] rdByte;

  nand_seq_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen),
    .busy(busy), .done(done), .pass(pass),
    .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .rdValid(rdValid), .rdData(rdData),
    .strb(strb), .cycDone(cycDone), .rdByte(rdByte)
  );

  nand_seq_dpath #(
    .WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI),
    .BUSY_DLY(BUSY_DLY)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .frdy(frdy), .fdqIn(fdqIn),
    .cycDone(cycDone), .rdByte(rdByte),
    .fceN(fceN), .fcle(fcle), .fale(fale), .fweN(fweN), .freN(freN),
    .fdqOut(fdqOut), .fdqOe(fdqOe)
  );

endmodule

// File: tb/nand_seq_top_tb_top.sv
`timescale 1ns/1ps
module nand_seq_top_tb_top;

  localparam int LEN_W = 10, WE_LO = 2, WE_HI = 1, RE_LO = 3, RE_HI = 2, BUSY_DLY = 2;
  localparam int LOGSZ = 1200;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, reqValid, wrValid;
  logic [1:0] reqOp;
  logic [23:0] reqAddr;
  logic [LEN_W-1:0] reqLen;
  logic [7:0] wrData, fdqIn;
  logic busy, done, pass, wrReady, rdValid;
  logic [7:0] rdData, fdqOut;
  logic fceN, fcle, fale, fweN, freN, fdqOe, frdy;

  nand_seq_top #(.LEN_W(LEN_W), .WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO),
                 .RE_HI(RE_HI), .BUSY_DLY(BUSY_DLY)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqLen(reqLen), .busy(busy), .done(done), .pass(pass), .wrValid(wrValid),
    .wrData(wrData), .wrReady(wrReady), .rdValid(rdValid), .rdData(rdData),
    .fceN(fceN), .fcle(fcle), .fale(fale), .fweN(fweN), .freN(freN),
    .fdqOut(fdqOut), .fdqOe(fdqOe), .fdqIn(fdqIn), .frdy(frdy));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] patByte(input logic [23:0] a, input int i);
    return a[7:0] ^ a[23:16] ^ 8'(i * 13 + 5);
  endfunction

  // ---------------- behavioural device model and bus monitors ----------------
  int logKind [LOGSZ];
  int logByte [LOGSZ];
  int logN = 0;
  logic [7:0] lastCmd = 8'hFF;
  logic [23:0] mAddr = '0;
  int addrCnt = 0, readIdx = 0, failsLeft = 0, busyLen = 1, busyLeft = 0;
  logic mRdy = 1'b1;
  logic weNq = 1'b1, reNq = 1'b1;
  int ceViol = 0, busyViol = 0, bothLow = 0, oeViol = 0;
  int weRun = 0, reRun = 0, weHiRun = 0, minWeLo = 999, minReLo = 999, minWeHi = 999;
  bit seenWe = 0;

  assign frdy  = mRdy;
  assign fdqIn = (lastCmd == 8'h70) ? {7'b0, (failsLeft != 0)} : patByte(mAddr, readIdx);

  always @(negedge clk) begin
    bit startBusy;
    startBusy = 0;
    if (!mRdy && (!fweN || !freN)) busyViol++;
    if (!fweN && !freN) bothLow++;
    if (fdqOe && !freN) oeViol++;
    if (fweN && !weNq) begin
      if (fceN) ceViol++;
      if (logN < LOGSZ) begin
        logKind[logN] = fcle ? 0 : (fale ? 1 : 2);
        logByte[logN] = fdqOut;
        logN++;
      end
      if (fcle) begin
        lastCmd = fdqOut;
        addrCnt = 0;
        if (fdqOut == 8'h10 || fdqOut == 8'hD0) startBusy = 1;
      end else if (fale) begin
        if (addrCnt < 3) mAddr[addrCnt*8 +: 8] = fdqOut;
        addrCnt++;
        if (lastCmd == 8'h00 && addrCnt == 3) begin
          startBusy = 1;
          readIdx = 0;
        end
      end
    end
    if (freN && !reNq) begin
      if (fceN) ceViol++;
      if (logN < LOGSZ) begin
        logKind[logN] = 3;
        logByte[logN] = fdqIn;
        logN++;
      end
      if (lastCmd == 8'h70) begin
        if (failsLeft > 0) failsLeft--;
      end else readIdx++;
    end
    if (startBusy) begin
      mRdy = 1'b0;
      busyLeft = busyLen;
    end else if (!mRdy) begin
      if (busyLeft == 0) mRdy = 1'b1;
      else busyLeft--;
    end
    // strobe width measurement
    if (!fweN) begin
      weRun++;
      if (seenWe && weHiRun > 0 && weHiRun < minWeHi) minWeHi = weHiRun;
      weHiRun = 0;
      seenWe = 1;
    end else begin
      if (weRun > 0 && weRun < minWeLo) minWeLo = weRun;
      weRun = 0;
      if (fceN) seenWe = 0;
      else weHiRun++;
    end
    if (!freN) reRun++;
    else begin
      if (reRun > 0 && reRun < minReLo) minReLo = reRun;
      reRun = 0;
    end
    weNq = fweN;
    reNq = freN;
  end

  // ---------------- expected trace ----------------
  int expKind [LOGSZ];
  int expByte [LOGSZ];
  int expN;
  logic [7:0] wdat [600];
  logic [7:0] rdBuf [600];

  task automatic pushExp(input int k, input int b);
    expKind[expN] = k;
    expByte[expN] = b;
    expN++;
  endtask

  task automatic buildExp(input int op, input logic [23:0] a, input int len, input int fails);
    expN = 0;
    if (op == 0) begin
      pushExp(0, 8'h00); pushExp(1, a[7:0]); pushExp(1, a[15:8]); pushExp(1, a[23:16]);
      for (int i = 0; i < len; i++) pushExp(3, patByte(a, i));
    end else if (op == 1) begin
      pushExp(0, 8'h80); pushExp(1, a[7:0]); pushExp(1, a[15:8]); pushExp(1, a[23:16]);
      for (int i = 0; i < len; i++) pushExp(2, wdat[i]);
      pushExp(0, 8'h10);
    end else begin
      for (int t = 0; t < ((fails >= 1) ? 2 : 1); t++) begin
        pushExp(0, 8'h60); pushExp(1, a[15:8]); pushExp(1, a[23:16]); pushExp(0, 8'hD0);
        pushExp(0, 8'h70); pushExp(3, (fails > t) ? 1 : 0);
      end
    end
  endtask

  function automatic string opTag(input int op);
    return (op == 0) ? "R4" : (op == 1) ? "R5" : "R6";
  endfunction

  task automatic runOp(input int op, input logic [23:0] a, input int len, input int fails, input bit poke);
    int cyc, rdN, wrIdx, kindBad, byteBad, firstBad, n0;
    bit hs, gotDone, gotPass, busyDrop, tmo;
    for (int i = 0; i < 600; i++) wdat[i] = 8'($urandom);
    logN = 0; failsLeft = fails; busyLen = 1 + int'($urandom % 12);
    ceViol = 0; busyViol = 0; bothLow = 0; oeViol = 0;
    rdN = 0; wrIdx = 0; hs = 0; gotDone = 0; gotPass = 0; busyDrop = 0; tmo = 0; cyc = 0;
    buildExp(op, a, len, fails);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqAddr = a; reqLen = LEN_W'(len);
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1 && fceN == 1'b0, "R3", "busy/ce after accept", {busy, fceN}, 2);
    forever begin
      if (hs) wrIdx++;
      if (rdValid && rdN < 600) begin rdBuf[rdN] = rdData; rdN++; end
      if (done) begin gotDone = 1; gotPass = pass; break; end
      if (!busy || fceN) busyDrop = 1;
      if (poke && cyc == 6) begin
        reqValid = 1'b1; reqOp = 2'(($urandom % 3)); reqAddr = 24'($urandom); reqLen = LEN_W'(5);
      end else reqValid = 1'b0;
      wrValid = (op == 1) && ($urandom % 3 != 0);
      wrData  = wdat[wrIdx % 600];
      hs = wrValid && wrReady;
      cyc++;
      if (cyc > 20000) begin tmo = 1; break; end
      @(negedge clk);
    end
    reqValid = 1'b0; wrValid = 1'b0;
    chk(!tmo && gotDone, "R3", "operation completes", gotDone, 1);
    chk(!busyDrop, "R3", "busy and ce held during op", busyDrop, 0);
    chk(fceN == 1'b1 && busy == 1'b0, "R3", "ce released with done", fceN, 1);
    chk(logN == expN, poke ? "R11" : opTag(op), "bus cycle count", logN, expN);
    kindBad = 0; byteBad = 0; firstBad = -1;
    for (int i = 0; i < expN && i < logN; i++) begin
      if (logKind[i] != expKind[i]) kindBad++;
      if (logByte[i] != expByte[i]) begin byteBad++; if (firstBad < 0) firstBad = i; end
    end
    chk(kindBad == 0, "R2", "latch kind mismatches", kindBad, 0);
    chk(byteBad == 0, opTag(op), "bus byte mismatches", byteBad,
        (firstBad >= 0) ? expByte[firstBad] : 0);
    if (op == 0) begin
      int bad;
      bad = 0;
      for (int i = 0; i < len && i < rdN; i++) if (rdBuf[i] != patByte(a, i)) bad++;
      chk(rdN == len && bad == 0, "R4", "host read bytes", rdN, len);
    end
    if (op == 1) chk(wrIdx == len, "R5", "host bytes taken", wrIdx, len);
    chk(gotPass == ((op == 2) ? (fails < 2) : 1'b1), (op == 2) ? "R8" : opTag(op),
        "pass flag", gotPass, (op == 2) ? int'(fails < 2) : 1);
    chk(busyViol == 0, "R7", "strobes while device busy", busyViol, 0);
    chk(ceViol == 0 && bothLow == 0 && oeViol == 0, "R10", "bus exclusivity violations",
        ceViol + bothLow + oeViol, 0);
    n0 = logN;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && logN == n0, poke ? "R11" : "R3", "idle after done", logN - n0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; reqOp = '0; reqAddr = '0; reqLen = '0;
    wrValid = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    chk(fceN && fweN && freN && !fcle && !fale && !busy && !done, "R1", "reset outputs",
        {fceN, fweN, freN, fcle, fale, busy, done}, 7'b1110000);
    rstN = 1'b1;
    @(negedge clk);
    chk(fceN && fweN && freN && !busy, "R1", "outputs after reset release",
        {fceN, fweN, freN, busy}, 4'b1110);

    // R12: opcode 3 ignored
    logN = 0;
    reqValid = 1'b1; reqOp = 2'd3; reqAddr = 24'h123456; reqLen = LEN_W'(4);
    @(negedge clk); reqValid = 1'b0;
    repeat (10) @(negedge clk);
    chk(!busy && fceN && logN == 0, "R12", "opcode 3 bus activity", logN, 0);

    // directed corners
    runOp(0, 24'h0A0B0C, 0, 0, 0);   // R13 read zero length
    runOp(1, 24'h102030, 0, 0, 0);   // R13 program zero length
    runOp(0, 24'hC35A71, 5, 0, 0);
    runOp(1, 24'h01F000, 528, 0, 0); // full page
    runOp(2, 24'h1FF000, 0, 0, 0);   // R8 pass first time
    runOp(2, 24'h003000, 0, 1, 0);   // R8 one retry then pass
    runOp(2, 24'h0AB000, 0, 2, 0);   // R8 two failures
    runOp(1, 24'h040506, 12, 0, 1);  // R11 request during program
    runOp(2, 24'h0CD000, 0, 1, 1);   // R11 request during erase

    // constrained random
    for (int k = 0; k < 16; k++) begin
      int op;
      op = int'($urandom % 3);
      runOp(op, 24'($urandom), (op == 2) ? 0 : int'($urandom % 41), int'($urandom % 3), 1'($urandom % 4 == 0));
    end

    chk(minWeLo >= WE_LO, "R9", "min write-enable low cycles", minWeLo, WE_LO);
    chk(minWeHi >= WE_HI, "R9", "min write-enable high cycles", minWeHi, WE_HI);
    chk(minReLo >= RE_LO, "R9", "min read-enable low cycles", minReLo, RE_LO);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule